// File: doc/BRIEF.md
# Dual-Rail C-Element with Set/Reset Latch

This block is a clocked behavioural model of a C-element for asynchronous control, in which every logical signal travels on a pair of wires. Each input and the output carry a true rail and a false rail. A set function and a reset function are formed separately, from the true rails and the false rails respectively. They steer a state-holding latch that keeps its value whenever neither function is active. No inverter appears anywhere on the signal path. Negation of an input or of the output is a parameter that swaps that signal's two rails.

The output never jumps straight from one code word to the other. It passes through the all-zero spacer for exactly one cycle. The block also watches its inputs for three kinds of misuse and records each one in a sticky flag:

- an invalid rail pair (both rails high);
- a set and a reset that are active together;
- an input that moves directly between its two code words without a spacer in between.

The design is synchronous, so every cycle can be observed at its ports.

Top module: `dr_celem`

## Requirements
- R1: A rail pair written {true,false} means logical 1 when 10, logical 0 when 01, and spacer (no data) when 00. Input lane i is {in_t[i],in_f[i]}, and the output is {x_t,x_f}.
- R2: The set function is the AND of all true input rails. If it is active at a clock edge while the output is 01 and no input is 11, the output becomes 00 after that edge and 10 after the next edge.
- R3: The reset function is the AND of all false input rails. If it is active at a clock edge while the output is 10 and no input is 11, the output becomes 00 after that edge and 01 after the next edge.
- R4: When neither function is active, a code-word output holds its value. Mixed logical inputs and spacer inputs therefore leave the output unchanged.
- R5: The output stays in spacer for exactly one cycle, and input values during that cycle do not alter the code word that follows. The output is never 11, and it never moves directly between 10 and 01.
- R6: Any input lane at 11 sets err_illegal from the next edge on, and the flag stays set until reset. In that cycle a code-word output does not change, even if the set or reset function is active.
- R7: When the set and reset functions are active in the same cycle (every input lane at 11), err_conflict is set from the next edge on and stays set until reset. The output does not change.
- R8: If any input lane holds one code word at one sampled edge and the opposite code word at the next, err_protocol is set from that edge on and stays set until reset. Passing through 00 or 11 between the two is not a violation. The first sample after reset is compared against spacer.
- R9: Bit i of IN_SWAP swaps the rails of input lane i, which negates it. OUT_SWAP swaps the output rails, so with OUT_SWAP=1 the logical 0 state appears as 10 on the ports.
- R10: While rst_n is low at a clock edge (synchronous, active low), the internal state returns to logical 0 (port value 01 with OUT_SWAP=0), all error flags clear, and the recorded previous inputs return to spacer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_t | input | N_IN | True rail of each input lane |
| in_f | input | N_IN | False rail of each input lane |
| x_t | output | 1 | True rail of the output |
| x_f | output | 1 | False rail of the output |
| err_illegal | output | 1 | Sticky: an input lane was seen at 11 |
| err_conflict | output | 1 | Sticky: set and reset were active together |
| err_protocol | output | 1 | Sticky: an input lane flipped code words with no spacer between |

## Verification
The hardest situation to reach from the ports is an input change that lands while the output sits in its one-cycle spacer. The input sequence must first push the output into spacer. Then, on the very next edge, it must present a value that would otherwise matter, while still obeying the spacer rule on every lane so that no protocol flag hides the result. The vector table does exactly this: a reset-all-zero step is followed at once by a partial-zero step, and a set step is followed by a repeated set. Conflict is reached only by driving every lane to 11 at once. Negation is covered by a second instance with swapped rails that receives its own stimulus.

// File: rtl/dr_celem_pkg.sv
// Shared encodings for the dual-rail C-element.
// Assumes a rail pair is always packed {true, false}.
package dr_celem_pkg;

    typedef enum logic [1:0] {
        RAIL_SPACER = 2'b00,
        RAIL_ZERO   = 2'b01,
        RAIL_ONE    = 2'b10,
        RAIL_BAD    = 2'b11
    } rail_code_e;

    // True when a pair holds one of the two code words.
    function automatic logic is_code(input logic [1:0] pair);
        return pair[1] ^ pair[0];
    endfunction

endpackage

// File: rtl/dr_rail_swap.sv
// Per-lane optional negation by exchanging rails; no logic gates.
// Assumes SWAP is fixed at elaboration.
module dr_rail_swap #(
    parameter int                N    = 2,
    parameter logic [N-1:0]      SWAP = '0
) (
    input  logic [N-1:0] raw_t,
    input  logic [N-1:0] raw_f,
    output logic [N-1:0] lg_t,
    output logic [N-1:0] lg_f
);

    for (genvar i = 0; i < N; i++) begin : g_lane
        if (SWAP[i]) begin : g_neg
            assign lg_t[i] = raw_f[i];
            assign lg_f[i] = raw_t[i];
        end else begin : g_pass
            assign lg_t[i] = raw_t[i];
            assign lg_f[i] = raw_f[i];
        end
    end

endmodule

// File: rtl/dr_setreset.sv
// Monotonic set/reset functions of the C-element plus invalid-pair detect.
// Set uses only true rails, reset only false rails: no inversion needed.
module dr_setreset #(
    parameter int N = 2
) (
    input  logic [N-1:0] lg_t,
    input  logic [N-1:0] lg_f,
    output logic         set_fn,
    output logic         rst_fn,
    output logic         any_bad
);

    // Combine rails into the two excitation functions and the 11 detector.
    always_comb begin
        set_fn  = &lg_t;
        rst_fn  = &lg_f;
        any_bad = |(lg_t & lg_f);
    end

endmodule

// File: rtl/dr_protocol_mon.sv
// Detects a lane jumping between code words on consecutive samples.
// Assumes the previous sample is spacer right after reset.
module dr_protocol_mon
    import dr_celem_pkg::*;
#(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] in_t,
    input  logic [N-1:0] in_f,
    output logic         viol
);

    logic [N-1:0] prev_t, prev_f;
    logic [N-1:0] lane_viol;

    // Remember last sampled rails of every lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_t <= '0;
            prev_f <= '0;
        end else begin
            prev_t <= in_t;
            prev_f <= in_f;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_lane
        assign lane_viol[i] = is_code({prev_t[i], prev_f[i]}) &&
                              is_code({in_t[i], in_f[i]}) &&
                              (prev_t[i] != in_t[i]);
    end

    assign viol = |lane_viol;

endmodule

// File: rtl/dr_rs_hold.sv
// RS-style state holder: set/reset move the state to spacer, and the
// pending code word is taken on the following edge. Holds when blocked.
module dr_rs_hold
    import dr_celem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_fn,
    input  logic rst_fn,
    input  logic blocked,
    output logic st_t,
    output logic st_f
);

    rail_code_e state_q, pend_q;

    // Advance the latch: spacer -> pending code word, or code word -> spacer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RAIL_ZERO;
            pend_q  <= RAIL_ZERO;
        end else if (state_q == RAIL_SPACER) begin
            state_q <= pend_q;
        end else if (!blocked) begin
            if (set_fn && state_q == RAIL_ZERO) begin
                state_q <= RAIL_SPACER;
                pend_q  <= RAIL_ONE;
            end else if (rst_fn && state_q == RAIL_ONE) begin
                state_q <= RAIL_SPACER;
                pend_q  <= RAIL_ZERO;
            end
        end
    end

    assign st_t = state_q[1];
    assign st_f = state_q[0];

endmodule

// File: rtl/dr_celem.sv
// Dual-rail C-element top: lane negation, set/reset functions, state
// holder, protocol monitor and sticky fault flags. Synchronous, active-low
// reset. Assumes inputs are stable around the rising clock edge.
module dr_celem #(
    parameter int               N_IN     = 2,
    parameter logic [N_IN-1:0]  IN_SWAP  = '0,
    parameter bit               OUT_SWAP = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] in_t,
    input  logic [N_IN-1:0] in_f,
    output logic            x_t,
    output logic            x_f,
    output logic            err_illegal,
    output logic            err_conflict,
    output logic            err_protocol
);

    logic [N_IN-1:0] lg_t, lg_f;
    logic set_fn, rst_fn, any_bad, viol;
    logic st_t, st_f;

    dr_rail_swap #(.N(N_IN), .SWAP(IN_SWAP)) u_swap (
        .raw_t(in_t), .raw_f(in_f), .lg_t(lg_t), .lg_f(lg_f)
    );

    dr_setreset #(.N(N_IN)) u_fn (
        .lg_t(lg_t), .lg_f(lg_f),
        .set_fn(set_fn), .rst_fn(rst_fn), .any_bad(any_bad)
    );

    dr_rs_hold u_hold (
        .clk(clk), .rst_n(rst_n), .set_fn(set_fn), .rst_fn(rst_fn),
        .blocked(any_bad), .st_t(st_t), .st_f(st_f)
    );

    dr_protocol_mon #(.N(N_IN)) u_mon (
        .clk(clk), .rst_n(rst_n), .in_t(in_t), .in_f(in_f), .viol(viol)
    );

    // Collect misuse events into flags that stay set until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_illegal  <= 1'b0;
            err_conflict <= 1'b0;
            err_protocol <= 1'b0;
        end else begin
            err_illegal  <= err_illegal  | any_bad;
            err_conflict <= err_conflict | (set_fn & rst_fn);
            err_protocol <= err_protocol | viol;
        end
    end

    if (OUT_SWAP) begin : g_out_neg
        assign x_t = st_f;
        assign x_f = st_t;
    end else begin : g_out_pass
        assign x_t = st_t;
        assign x_f = st_f;
    end

endmodule

// File: rtl/dr_celem_chk.sv
// Property checker for dr_celem, attached to every instance by bind.
// Works on the internal logical state so rail swapping does not matter.
module dr_celem_chk (
    input logic clk,
    input logic rst_n,
    input logic set_fn,
    input logic rst_fn,
    input logic any_bad,
    input logic st_t,
    input logic st_f,
    input logic err_illegal,
    input logic err_conflict,
    input logic err_protocol
);

    a_r5_never_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_t && st_f));

    a_r5_spacer_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_t && !st_f) |=> (st_t != st_f));

    a_r5_no_flip_up: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_t && st_f) |=> !(st_t && !st_f));

    a_r5_no_flip_down: assert property (@(posedge clk) disable iff (!rst_n)
        (st_t && !st_f) |=> !(!st_t && st_f));

    a_r2_set_to_spacer: assert property (@(posedge clk) disable iff (!rst_n)
        (set_fn && !any_bad && !st_t && st_f) |=> (!st_t && !st_f));

    a_r3_reset_to_spacer: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_fn && !any_bad && st_t && !st_f) |=> (!st_t && !st_f));

    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_fn && !rst_fn && (st_t != st_f)) |=> $stable({st_t, st_f}));

    a_r6_bad_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (any_bad && (st_t != st_f)) |=> $stable({st_t, st_f}));

    a_r6_bad_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        any_bad |=> err_illegal);

    a_r6_illegal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_illegal |=> err_illegal);

    a_r7_conflict_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (set_fn && rst_fn) |=> err_conflict);

    a_r7_conflict_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_conflict |=> err_conflict);

    a_r8_protocol_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_protocol |=> err_protocol);

endmodule

bind dr_celem dr_celem_chk u_chk (
    .clk(clk), .rst_n(rst_n), .set_fn(set_fn), .rst_fn(rst_fn),
    .any_bad(any_bad), .st_t(st_t), .st_f(st_f),
    .err_illegal(err_illegal), .err_conflict(err_conflict),
    .err_protocol(err_protocol)
);

// File: tb/tb_dr_celem.sv
// Self-checking bench: vector table for the main function, then directed
// tests for reset, faults and rail swapping.
module tb_dr_celem;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] in_t = '0, in_f = '0;
    logic [1:0] n_t = '0, n_f = '0;
    logic x_t, x_f, e_ill, e_con, e_pro;
    logic nx_t, nx_f, ne_ill, ne_con, ne_pro;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    dr_celem #(.N_IN(2)) dut (
        .clk(clk), .rst_n(rst_n), .in_t(in_t), .in_f(in_f),
        .x_t(x_t), .x_f(x_f), .err_illegal(e_ill),
        .err_conflict(e_con), .err_protocol(e_pro)
    );

    // Second instance: lane 0 negated, output negated (R9).
    dr_celem #(.N_IN(2), .IN_SWAP(2'b01), .OUT_SWAP(1'b1)) dut_neg (
        .clk(clk), .rst_n(rst_n), .in_t(n_t), .in_f(n_f),
        .x_t(nx_t), .x_f(nx_f), .err_illegal(ne_ill),
        .err_conflict(ne_con), .err_protocol(ne_pro)
    );

    // {in_t, in_f, expected {x_t,x_f}, expected {illegal,conflict,protocol}}
    localparam logic [8:0] VEC [13] = '{
        9'b00_00_01_000,  // R4 spacers hold 0
        9'b11_00_00_000,  // R2 all ones -> spacer
        9'b00_00_10_000,  // R2 then code word 1
        9'b01_10_10_000,  // R4 mixed holds
        9'b00_00_10_000,  // R4 spacer holds
        9'b00_11_00_000,  // R3 all zeros -> spacer
        9'b00_01_01_000,  // R5 input during spacer ignored
        9'b00_11_01_000,  // R4 reset while already 0
        9'b00_00_01_000,  // R4
        9'b10_00_01_000,  // R4 partial ones hold
        9'b11_00_00_000,  // R2 set again
        9'b11_00_10_000,  // R5 set during spacer, single cycle
        9'b11_00_10_000   // R4 set while already 1 holds
    };

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, return at falling edge.
    task automatic step(input logic [1:0] t, input logic [1:0] f);
        in_t = t;
        in_f = f;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        in_t = '0; in_f = '0; n_t = '0; n_f = '0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // R10 reset state
        check("R10 reset output", {2'b00, x_t, x_f}, 4'b0001);
        check("R10 reset flags", {1'b0, e_ill, e_con, e_pro}, 4'b0000);
        check("R9 negated reset output", {2'b00, nx_t, nx_f}, 4'b0010);

        for (int i = 0; i < 13; i++) begin
            step(VEC[i][8:7], VEC[i][6:5]);
            check($sformatf("table(R1,R2,R3,R4,R5) vec %0d out", i),
                  {2'b00, x_t, x_f}, {2'b00, VEC[i][4:3]});
            check($sformatf("table(R8) vec %0d flags", i),
                  {1'b0, e_ill, e_con, e_pro}, {1'b0, VEC[i][2:0]});
        end

        // R6: lane 0 at 11 while set function active; output must hold
        do_reset();
        step(2'b11, 2'b01);
        check("R6 output held on 11", {2'b00, x_t, x_f}, 4'b0001);
        check("R6 illegal flag", {1'b0, e_ill, e_con, e_pro}, 4'b0100);
        step(2'b00, 2'b00);
        check("R6 illegal sticky", {1'b0, e_ill, e_con, e_pro}, 4'b0100);

        // R7: every lane 11 -> set and reset together
        do_reset();
        step(2'b11, 2'b11);
        check("R7 conflict flags", {1'b0, e_ill, e_con, e_pro}, 4'b0110);
        check("R7 output held", {2'b00, x_t, x_f}, 4'b0001);
        step(2'b00, 2'b00);
        check("R7 conflict sticky", {1'b0, e_ill, e_con, e_pro}, 4'b0110);

        // R8: lane code words swap with no spacer between
        do_reset();
        step(2'b01, 2'b10);
        check("R8 first sample clean", {1'b0, e_ill, e_con, e_pro}, 4'b0000);
        step(2'b10, 2'b01);
        check("R8 direct flip flagged", {1'b0, e_ill, e_con, e_pro}, 4'b0001);
        check("R8 output held (mixed)", {2'b00, x_t, x_f}, 4'b0001);
        step(2'b00, 2'b00);
        check("R8 protocol sticky", {1'b0, e_ill, e_con, e_pro}, 4'b0001);
        do_reset();
        check("R10 flags cleared after faults", {1'b0, e_ill, e_con, e_pro}, 4'b0000);

        // R9: raw lane 0 = 01 (negated to 1), lane 1 = 10 -> set on dut_neg
        n_t = 2'b10; n_f = 2'b01;
        step(2'b00, 2'b00);
        check("R9 negated set enters spacer", {2'b00, nx_t, nx_f}, 4'b0000);
        check("R9 plain instance untouched", {2'b00, x_t, x_f}, 4'b0001);
        n_t = 2'b00; n_f = 2'b00;
        step(2'b00, 2'b00);
        check("R9 negated output shows 01 for logical 1", {2'b00, nx_t, nx_f}, 4'b0001);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule